// File: doc/BRIEF.md
# Multi-Queue FIFO Write Port

This block is the write side of a FIFO store that is divided into up to eight independent queues. The queues share one data input, one clock and one active-low write enable. A separate address bus, qualified by an address-enable strobe, chooses which queue receives the writes. The upper three address bits are a device select. They are compared with a static three-bit identity input, so several devices can sit on one bus and only the addressed one reacts.

A change of queue is pipelined and completes after several clock edges. Writes are still accepted on every edge while the switch is pending, so the write bus can run at full rate without gaps. Each queue keeps its own write pointer, read pointer and occupancy count over one shared storage array. A full flag reports the state of the queue that is currently active. A plain read port, with a queue number and a registered data output, lets a test environment drain any queue and check the order of its words.

The selector is a four-state machine. `SW_IDLE` means no switch is pending. A valid select moves it to `SW_WAIT1`, then to `SW_WAIT2`, then to `SW_COMMIT`. In `SW_COMMIT` the pending queue becomes the write target, and the machine returns to `SW_IDLE`. From any state, a new valid select goes back to `SW_WAIT1` and records the new address.

Top module: `mq_write_port`

## Requirements
- R1: After reset, queue 0 is the active queue, every queue is empty, `full` is low, `rd_valid` is low and no switch is pending.
- R2: A queue select is captured on a rising clock edge when `wadd_en` is high and `wadd[7:5]` equals `dev_id`. The level of `wen_n` has no influence on selection.
- R3: A write accepted on the capturing edge, or on either of the next two edges, goes to the previously active queue. A write on the third edge after capture goes to the newly selected queue. From that edge on, `full` reflects the new queue.
- R4: Once a switch has completed, every write goes to the same queue until another valid select completes.
- R5: A word can be written on every consecutive clock edge, including the edges during a pending switch. No word is lost while the queue has room.
- R6: When `wen_n` is high, no word is stored in any queue.
- R7: Each queue holds DEPTH (16) words. A write to a queue that already holds 16 words is dropped. `full` is high exactly when the active queue holds 16 words.
- R8: A select whose `wadd[7:5]` differs from `dev_id` is ignored. The active queue and any pending switch are left unchanged.
- R9: The queue number is `wadd[QADDR_W-1:0]` (bits [2:0] with the default of 8 queues). Address bits between the queue number and bit 5 are ignored.
- R10: A valid select that arrives while a switch is pending restarts the switch with the newer address. The new queue takes over on the third edge after the latest select.
- R11: With `rd_en` high, the word at the head of queue `rd_q` appears on `rd_data` with `rd_valid` high after the next edge. Words leave each queue in write order. A read of an empty queue returns `rd_valid` low and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DATA_W (36) | Write data |
| wen_n | input | 1 | Active-low write enable |
| wadd | input | 8 | Write address: [7:5] device select, low bits queue number |
| wadd_en | input | 1 | Qualifies `wadd` as a queue select |
| dev_id | input | 3 | Static identity compared with `wadd[7:5]` |
| full | output | 1 | Active queue holds DEPTH words |
| rd_en | input | 1 | Read request |
| rd_q | input | QADDR_W (3) | Queue to read |
| rd_data | output | DATA_W (36) | Registered read data |
| rd_valid | output | 1 | `rd_data` holds a word read on the last edge |

## Verification
The bench streams words on every edge across a queue switch and then drains each queue. A design with the wrong switch latency would put words into the neighbouring queue, so the drain would show them in the wrong queue or out of order. It issues a select while `wen_n` is high, a select with a mismatched device field, and an address with the ignored middle bits set. These catch a selector that waits for a write, that ignores the identity check, or that decodes too many bits. It also restarts a pending switch, which catches a design that commits the first address. It overfills one queue, which catches a design that wraps a pointer and overwrites old data. Finally it reads empty queues, which catches a design that returns stale words.

// File: rtl/mqw_pkg.sv
package mqw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_WAIT1  = 2'd1,
        SW_WAIT2  = 2'd2,
        SW_COMMIT = 2'd3
    } sw_state_t;

endpackage

// File: rtl/mqw_select_fsm.sv
module mqw_select_fsm
    import mqw_pkg::*;
#(
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_ok,
    input  logic [QW-1:0] sel_q,
    output logic [QW-1:0] active_q,
    output logic [QW-1:0] target_q
);

    sw_state_t     state, state_nx;
    logic [QW-1:0] pend_q;

    // state register with pending and active queue numbers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SW_IDLE;
            pend_q   <= '0;
            active_q <= '0;
        end else begin
            state <= state_nx;
            if (sel_ok)
                pend_q <= sel_q;
            if (state == SW_COMMIT && !sel_ok)
                active_q <= pend_q;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SW_IDLE:   state_nx = sel_ok ? SW_WAIT1 : SW_IDLE;
            SW_WAIT1:  state_nx = sel_ok ? SW_WAIT1 : SW_WAIT2;
            SW_WAIT2:  state_nx = sel_ok ? SW_WAIT1 : SW_COMMIT;
            SW_COMMIT: state_nx = sel_ok ? SW_WAIT1 : SW_IDLE;
        endcase
    end

    // outputs: the pending queue takes writes in the commit state
    always_comb begin
        target_q = active_q;
        unique case (state)
            SW_IDLE, SW_WAIT1, SW_WAIT2: target_q = active_q;
            SW_COMMIT:                   target_q = pend_q;
        endcase
    end

    AST_SWITCH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_COMMIT && !sel_ok) |=> (active_q == $past(pend_q) && state == SW_IDLE)); // R3

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SW_COMMIT) |=> $stable(active_q)); // R4

    AST_SELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok |=> (state == SW_WAIT1 && $stable(active_q))); // R10

endmodule

// File: rtl/mqw_queue_store.sv
module mqw_queue_store #(
    parameter int DW    = 36,
    parameter int QW    = 3,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_q,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [QW-1:0] rd_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [(1<<QW)-1:0] q_full
);

    localparam int NQ = 1 << QW;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [NQ*DEPTH];
    logic [PW-1:0] wptr_a [NQ];
    logic [PW-1:0] rptr_a [NQ];
    logic [CW-1:0] cnt_a  [NQ];
    logic          wr_fire, rd_fire;

    assign wr_fire = wr_en && !q_full[wr_q];
    assign rd_fire = rd_en && (cnt_a[rd_q] != '0);

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        logic [PW-1:0] wptr_r, rptr_r;
        logic [CW-1:0] cnt_r;
        logic          wf, rf;

        assign wf = wr_fire && (wr_q == QW'(g));
        assign rf = rd_fire && (rd_q == QW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wptr_r <= '0;
                rptr_r <= '0;
                cnt_r  <= '0;
            end else begin
                if (wf) wptr_r <= wptr_r + 1'b1;
                if (rf) rptr_r <= rptr_r + 1'b1;
                if (wf && !rf)      cnt_r <= cnt_r + 1'b1;
                else if (rf && !wf) cnt_r <= cnt_r - 1'b1;
            end
        end

        assign wptr_a[g] = wptr_r;
        assign rptr_a[g] = rptr_r;
        assign cnt_a[g]  = cnt_r;
        assign q_full[g] = (cnt_r == CW'(DEPTH));

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_r <= CW'(DEPTH)); // R7

        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !rd_en) |=> $stable(cnt_r)); // R6
    end

    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[{wr_q, wptr_a[wr_q]}] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire)
                rd_data <= mem[{rd_q, rptr_a[rd_q]}];
        end
    end

    AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cnt_a[wr_q] == CW'(DEPTH) && !(rd_en && rd_q == wr_q))
        |=> cnt_a[$past(wr_q)] == CW'(DEPTH)); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cnt_a[wr_q] != CW'(DEPTH) && !(rd_en && rd_q == wr_q))
        |=> cnt_a[$past(wr_q)] == $past(cnt_a[wr_q]) + 1'b1); // R5

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt_a[rd_q] == '0) |=> !rd_valid); // R11

endmodule

// File: rtl/mq_write_port.sv
module mq_write_port #(
    parameter int DATA_W  = 36,
    parameter int QADDR_W = 3,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  din,
    input  logic               wen_n,
    input  logic [7:0]         wadd,
    input  logic               wadd_en,
    input  logic [2:0]         dev_id,
    output logic               full,
    input  logic               rd_en,
    input  logic [QADDR_W-1:0] rd_q,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid
);

    localparam int NQ = 1 << QADDR_W;

    logic               sel_ok;
    logic [QADDR_W-1:0] active_q, target_q;
    logic [NQ-1:0]      q_full;

    assign sel_ok = wadd_en && (wadd[7:5] == dev_id);

    mqw_select_fsm #(.QW(QADDR_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_ok   (sel_ok),
        .sel_q    (wadd[QADDR_W-1:0]),
        .active_q (active_q),
        .target_q (target_q)
    );

    mqw_queue_store #(.DW(DATA_W), .QW(QADDR_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (!wen_n),
        .wr_q     (target_q),
        .wr_data  (din),
        .rd_en    (rd_en),
        .rd_q     (rd_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .q_full   (q_full)
    );

    assign full = q_full[active_q];

    AST_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wadd_en && wadd[7:5] != dev_id && active_q == target_q) |=> $stable(active_q)); // R8

endmodule

// File: tb/mq_write_port_test.sv
module mq_write_port_test;

    localparam logic [2:0] ID = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] din = '0;
    logic        wen_n = 1'b1;
    logic [7:0]  wadd = '0;
    logic        wadd_en = 1'b0;
    logic        full;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_q = '0;
    logic [35:0] rd_data;
    logic        rd_valid;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;

    logic [35:0] mq [8][$];
    logic [35:0] exp_rd [$];
    string       exp_tag [$];
    logic [2:0]  m_act = '0;
    logic [2:0]  m_pend = '0;
    int          m_sw = 0;
    logic [35:0] seq = 36'h1000;

    always #5 clk = ~clk;

    mq_write_port uut (
        .clk(clk), .rst_n(rst_n), .din(din), .wen_n(wen_n), .wadd(wadd),
        .wadd_en(wadd_en), .dev_id(ID), .full(full), .rd_en(rd_en),
        .rd_q(rd_q), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R11 unexpected rd_valid", rd_data, 36'h0);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_rd.pop_front();
                t = exp_tag.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    // driver: one clock of stimulus plus the reference model
    task automatic step(input logic wn, input logic ae, input logic [7:0] a,
                        input logic re, input logic [2:0] rq, input string tag);
        logic [2:0]  tgt;
        logic [35:0] d;
        bit          wr_ok, rd_ok;
        d = seq;
        if (!wn) seq = seq + 1;
        wen_n = wn; din = d; wadd_en = ae; wadd = a; rd_en = re; rd_q = rq;
        @(posedge clk);
        tgt   = (m_sw == 3) ? m_pend : m_act;
        rd_ok = re && mq[rq].size() > 0;
        wr_ok = !wn && mq[tgt].size() < 16;
        if (rd_ok) begin
            exp_rd.push_back(mq[rq].pop_front());
            exp_tag.push_back(tag);
        end
        if (wr_ok) mq[tgt].push_back(d);
        if (ae && a[7:5] == ID) begin
            m_pend = a[2:0];
            m_sw = 1;
        end else if (m_sw == 3) begin
            m_act = m_pend;
            m_sw = 0;
        end else if (m_sw != 0) begin
            m_sw++;
        end
        @(negedge clk);
        check(full == (mq[m_act].size() == 16), {tag, " full flag R7"},
              {35'h0, full}, {35'h0, mq[m_act].size() == 16});
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'd0, tag);
    endtask

    task automatic wr(input string tag);
        step(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, tag);
    endtask

    task automatic drain(input string tag);
        for (int q = 0; q < 8; q++) begin
            while (mq[q].size() > 0)
                step(1'b1, 1'b0, 8'h00, 1'b1, 3'(q), tag);
            step(1'b1, 1'b0, 8'h00, 1'b1, 3'(q), "R11 empty read");
        end
        idle(tag);
        check(exp_rd.size() == 0, {tag, " read count"}, 36'(exp_rd.size()), 36'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(full == 1'b0, "R1 full after reset", {35'h0, full}, 36'h0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", {35'h0, rd_valid}, 36'h0);
        drain("R1");

        // R4: writes stay on queue 0
        for (int i = 0; i < 5; i++) wr("R4");
        drain("R4");

        // R3 / R5: continuous writes across a switch to queue 3
        for (int i = 0; i < 10; i++)
            step(1'b0, i == 2, {ID, 2'b00, 3'd3}, 1'b0, 3'd0, "R3 R5");
        drain("R3 R5");

        // R2 / R6: select with writes disabled, then write
        step(1'b1, 1'b1, {ID, 2'b00, 3'd1}, 1'b0, 3'd0, "R2 R6");
        for (int i = 0; i < 3; i++) idle("R6");
        for (int i = 0; i < 4; i++) wr("R2");
        drain("R2");

        // R8: mismatched device select ignored
        for (int i = 0; i < 8; i++)
            step(1'b0, i == 1, {3'b010, 2'b00, 3'd4}, 1'b0, 3'd0, "R8");
        drain("R8");

        // R9: middle address bits ignored
        for (int i = 0; i < 8; i++)
            step(1'b0, i == 0, {ID, 2'b11, 3'd5}, 1'b0, 3'd0, "R9");
        drain("R9");

        // R10: restart a pending switch
        step(1'b0, 1'b1, {ID, 2'b00, 3'd2}, 1'b0, 3'd0, "R10");
        step(1'b0, 1'b1, {ID, 2'b00, 3'd7}, 1'b0, 3'd0, "R10");
        for (int i = 0; i < 6; i++) wr("R10");
        drain("R10");

        // R7: overfill queue 6
        step(1'b1, 1'b1, {ID, 2'b00, 3'd6}, 1'b0, 3'd0, "R7");
        for (int i = 0; i < 3; i++) idle("R7");
        for (int i = 0; i < 18; i++) wr("R7");
        check(full == 1'b1, "R7 full after overfill", {35'h0, full}, 36'h1);
        // R11: read and write together on a full queue
        step(1'b0, 1'b0, 8'h00, 1'b1, 3'd6, "R11 R7");
        drain("R7 R11");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule